// File: doc/BRIEF.md
# Banked Clock Divider with Enable Gating

This block turns one fast source clock into three banks of derived clocks. Each bank has two outputs, and both outputs of a bank always carry the same waveform. Banks A and B divide by 2 or by 4, and bank C divides by 4 or by 6. A select input per bank picks the ratio. A shared halving control doubles every ratio. The source events come either from the fast clock itself (multiplied path) or from rising edges of a slower reference level sampled in the fast domain (bypass path). A two-bit gate code chooses which banks run. A bank that is stopped sits low. It is started and stopped only at a period boundary, so an output never shows a short pulse.

The design works in one clock domain. An input *event* is one fast-clock cycle in which the selected source has an edge. Each bank runs a three-state machine:

- **PARK**: output low, counter cleared.
- **HIGH**: first half of a period.
- **LOW**: second half of a period.

The transitions are:

- **start**: PARK to HIGH, on an event while the bank is allowed to run.
- **fall**: HIGH to LOW, on the last event of the high half.
- **repeat**: LOW to HIGH, on the last event of the low half while the bank is allowed to run.
- **stop**: LOW to PARK, on the last event of the low half while the bank is not allowed to run.

The bank loads its half-period length (select and halving together) only on start and repeat.

An active-low master reset clears every state machine and counter at once and drops the output-enable flag.

Top module: `banked_clock_divider`

## Requirements
- R1: Bank A output period, counted in events, is 2 when `div_sel_a`=0 and 4 when it is 1, with equal high and low halves.
- R2: Bank B output period is 2 when `div_sel_b`=0 and 4 when it is 1, with equal high and low halves.
- R3: Bank C output period is 4 when `div_sel_c`=0 and 6 when it is 1, with equal high and low halves (2+2 or 3+3 events).
- R4: With `half_mode`=1 every bank period doubles: A and B become 4 or 8, and C becomes 8 or 12.
- R5: Banks allowed to run, by `gate_code` value:
    - 2'b00: A only.
    - 2'b01: C only.
    - 2'b10: A and C.
    - 2'b11: A, B and C.

  A bank that is not allowed stays low once it has parked.
- R6: With `mult_sel`=1 every fast-clock cycle is an event. With `mult_sel`=0 an event is a cycle in which `ref_lvl` is 1 and was 0 in the previous cycle. Outputs change only on events, registered one cycle later.
- R7: While `mreset_n`=0, all outputs and `out_en` are 0 and all dividers are cleared. After release, every allowed bank goes high on the same first event.
- R8: The two outputs of a bank are equal in every cycle.
- R9: A bank stops only after completing a full low half, and a restart always begins with a full high half.
- R10: A change of a bank's select or of `half_mode` takes effect only at that bank's next period boundary.
- R11: `out_en` rises on the first clock edge after `mreset_n` returns to 1 and stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock, standing in for the multiplied clock |
| mreset_n | input | 1 | Active-low master reset, asynchronous assert |
| mult_sel | input | 1 | 1: every cycle is an event; 0: reference rising edges are events |
| ref_lvl | input | 1 | Reference clock level, sampled in the `clk` domain |
| half_mode | input | 1 | 1 doubles every bank ratio |
| div_sel_a | input | 1 | Bank A ratio select |
| div_sel_b | input | 1 | Bank B ratio select |
| div_sel_c | input | 1 | Bank C ratio select |
| gate_code | input | 2 | Bank run selection code |
| qa | output | OUTS | Bank A outputs |
| qb | output | OUTS | Bank B outputs |
| qc | output | OUTS | Bank C outputs |
| out_en | output | 1 | 1 when outputs are enabled (not in reset) |

## Verification
The assertions take for granted that control inputs are synchronous to `clk` and steady across each rising edge, and that `ref_lvl` is a level already in the `clk` domain, so the edge detector never sees a metastable sample. The stimulus drives every input on the falling edge only. Select, halving and gate changes are placed at arbitrary points, including in the middle of a high half, to exercise the boundary rules. The reference level follows a fixed 2-high, 3-low pattern in bypass.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        PH_PARK = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } bank_phase_e;

    localparam int NUM_BANKS = 3;

    // Run mask {C,B,A} for each gate code value
    function automatic logic [NUM_BANKS-1:0] gate_to_mask(input logic [1:0] code);
        logic [NUM_BANKS-1:0] m;
        unique case (code)
            2'b00:   m = 3'b001;
            2'b01:   m = 3'b100;
            2'b10:   m = 3'b101;
            default: m = 3'b111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/clkdiv_event_sel.sv
module clkdiv_event_sel (
    input  logic clk,
    input  logic mreset_n,
    input  logic mult_sel,
    input  logic ref_lvl,
    output logic ev
);
    logic ref_q;

    always_ff @(posedge clk or negedge mreset_n) begin
        if (!mreset_n) ref_q <= 1'b0;
        else           ref_q <= ref_lvl;
    end

    // Multiplied path: every cycle; bypass: reference rising edge
    always_comb begin
        ev = mult_sel | (ref_lvl & ~ref_q);
    end
endmodule

// File: rtl/clkdiv_run_decode.sv
module clkdiv_run_decode
    import clkdiv_pkg::*;
(
    input  logic [1:0]           gate_code,
    output logic [NUM_BANKS-1:0] run_mask
);
    always_comb begin
        run_mask = gate_to_mask(gate_code);
    end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int HALF_SEL0 = 1,
    parameter int HALF_SEL1 = 2,
    parameter int OUTS      = 2,
    parameter int CNT_W     = 4
) (
    input  logic            clk,
    input  logic            mreset_n,
    input  logic            ev,
    input  logic            run,
    input  logic            div_sel,
    input  logic            halve,
    output logic [OUTS-1:0] q
);
    bank_phase_e      st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] half_q, half_nx;
    logic [CNT_W-1:0] base_half, half_new;
    logic             last_ev;

    always_comb begin
        base_half = div_sel ? CNT_W'(HALF_SEL1) : CNT_W'(HALF_SEL0);
        half_new  = halve ? (base_half << 1) : base_half;
        last_ev   = ev && (cnt_q == half_q - CNT_W'(1));
    end

    always_comb begin
        st_nx   = st_q;
        cnt_nx  = cnt_q;
        half_nx = half_q;
        unique case (st_q)
            PH_PARK: begin
                if (ev && run) begin          // start
                    st_nx   = PH_HIGH;
                    cnt_nx  = '0;
                    half_nx = half_new;
                end
            end
            PH_HIGH: begin
                if (last_ev) begin            // fall
                    st_nx  = PH_LOW;
                    cnt_nx = '0;
                end else if (ev) begin
                    cnt_nx = cnt_q + CNT_W'(1);
                end
            end
            PH_LOW: begin
                if (last_ev) begin
                    cnt_nx = '0;
                    if (run) begin            // repeat
                        st_nx   = PH_HIGH;
                        half_nx = half_new;
                    end else begin            // stop
                        st_nx = PH_PARK;
                    end
                end else if (ev) begin
                    cnt_nx = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                st_nx  = PH_PARK;
                cnt_nx = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge mreset_n) begin
        if (!mreset_n) begin
            st_q   <= PH_PARK;
            cnt_q  <= '0;
            half_q <= CNT_W'(HALF_SEL0);
        end else begin
            st_q   <= st_nx;
            cnt_q  <= cnt_nx;
            half_q <= half_nx;
        end
    end

    // Output register, one flop per output
    generate
        for (genvar i = 0; i < OUTS; i++) begin : g_out
            always_ff @(posedge clk or negedge mreset_n) begin
                if (!mreset_n) q[i] <= 1'b0;
                else           q[i] <= (st_nx == PH_HIGH);
            end
        end
    endgenerate
endmodule

// File: rtl/banked_clock_divider.sv
module banked_clock_divider
    import clkdiv_pkg::*;
#(
    parameter int OUTS   = 2,
    parameter int A_HALF0 = 1,
    parameter int A_HALF1 = 2,
    parameter int B_HALF0 = 1,
    parameter int B_HALF1 = 2,
    parameter int C_HALF0 = 2,
    parameter int C_HALF1 = 3
) (
    input  logic            clk,
    input  logic            mreset_n,
    input  logic            mult_sel,
    input  logic            ref_lvl,
    input  logic            half_mode,
    input  logic            div_sel_a,
    input  logic            div_sel_b,
    input  logic            div_sel_c,
    input  logic [1:0]      gate_code,
    output logic [OUTS-1:0] qa,
    output logic [OUTS-1:0] qb,
    output logic [OUTS-1:0] qc,
    output logic            out_en
);
    localparam int HALF0 [NUM_BANKS] = '{A_HALF0, B_HALF0, C_HALF0};
    localparam int HALF1 [NUM_BANKS] = '{A_HALF1, B_HALF1, C_HALF1};
    localparam int MAX_HALF = 2 * C_HALF1;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    logic                 div_ev;
    logic [NUM_BANKS-1:0] run_mask;
    logic [NUM_BANKS-1:0] sel_v;
    logic [OUTS-1:0]      bank_q [NUM_BANKS];

    assign sel_v = {div_sel_c, div_sel_b, div_sel_a};

    clkdiv_event_sel u_evsel (
        .clk      (clk),
        .mreset_n (mreset_n),
        .mult_sel (mult_sel),
        .ref_lvl  (ref_lvl),
        .ev       (div_ev)
    );

    clkdiv_run_decode u_rundec (
        .gate_code (gate_code),
        .run_mask  (run_mask)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            clkdiv_bank #(
                .HALF_SEL0 (HALF0[b]),
                .HALF_SEL1 (HALF1[b]),
                .OUTS      (OUTS),
                .CNT_W     (CNT_W)
            ) u_bank (
                .clk      (clk),
                .mreset_n (mreset_n),
                .ev       (div_ev),
                .run      (run_mask[b]),
                .div_sel  (sel_v[b]),
                .halve    (half_mode),
                .q        (bank_q[b])
            );
        end
    endgenerate

    assign qa = bank_q[0];
    assign qb = bank_q[1];
    assign qc = bank_q[2];

    always_ff @(posedge clk or negedge mreset_n) begin
        if (!mreset_n) out_en <= 1'b0;
        else           out_en <= 1'b1;
    end
endmodule

// File: rtl/banked_clock_divider_chk.sv
module banked_clock_divider_chk #(
    parameter int OUTS = 2
) (
    input logic            clk,
    input logic            mreset_n,
    input logic            div_ev,
    input logic [1:0]      gate_code,
    input logic [OUTS-1:0] qa,
    input logic [OUTS-1:0] qb,
    input logic [OUTS-1:0] qc,
    input logic            out_en
);
    AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!mreset_n)
        $past(mreset_n) |-> out_en); // R11

    AST_A_GATED: assert property (@(posedge clk) disable iff (!mreset_n)
        $rose(qa[0]) |-> ($past(gate_code) != 2'b01)); // R5

    AST_B_GATED: assert property (@(posedge clk) disable iff (!mreset_n)
        $rose(qb[0]) |-> ($past(gate_code) == 2'b11)); // R5

    AST_C_GATED: assert property (@(posedge clk) disable iff (!mreset_n)
        $rose(qc[0]) |-> ($past(gate_code) != 2'b00)); // R5

    AST_QUIET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!mreset_n)
        !div_ev |=> $stable({qa, qb, qc})); // R6

    AST_RISE_ON_EVENT: assert property (@(posedge clk) disable iff (!mreset_n)
        $rose(qc[0]) |-> $past(div_ev)); // R6

    AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!mreset_n)
        (qa == {OUTS{qa[0]}}) && (qb == {OUTS{qb[0]}}) && (qc == {OUTS{qc[0]}})); // R8
endmodule

bind banked_clock_divider banked_clock_divider_chk #(.OUTS(OUTS)) u_chk (
    .clk       (clk),
    .mreset_n  (mreset_n),
    .div_ev    (div_ev),
    .gate_code (gate_code),
    .qa        (qa),
    .qb        (qb),
    .qc        (qc),
    .out_en    (out_en)
);

// File: tb/banked_clock_divider_bench.sv
`timescale 1ns/1ps
module banked_clock_divider_bench;
    logic       clk = 1'b0;
    logic       mreset_n = 1'b0;
    logic       mult_sel = 1'b1;
    logic       ref_lvl = 1'b0;
    logic       half_mode = 1'b0;
    logic       div_sel_a = 1'b0;
    logic       div_sel_b = 1'b0;
    logic       div_sel_c = 1'b0;
    logic [1:0] gate_code = 2'b11;
    logic [1:0] qa, qb, qc;
    logic       out_en;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    ref_auto = 0;
    int    ref_ph = 0;
    string phase_tag = "R7";

    // behavioural reference state
    int running [3];
    int pos [3];
    int per [3];
    bit refp = 0;
    bit oe_m = 0;

    always #4 clk = ~clk;

    banked_clock_divider u_banked_clock_divider (
        .clk(clk), .mreset_n(mreset_n), .mult_sel(mult_sel), .ref_lvl(ref_lvl),
        .half_mode(half_mode), .div_sel_a(div_sel_a), .div_sel_b(div_sel_b),
        .div_sel_c(div_sel_c), .gate_code(gate_code),
        .qa(qa), .qb(qb), .qc(qc), .out_en(out_en)
    );

    function automatic int new_period(int b);
        int p;
        if (b == 0)      p = div_sel_a ? 4 : 2;
        else if (b == 1) p = div_sel_b ? 4 : 2;
        else             p = div_sel_c ? 6 : 4;
        return half_mode ? 2 * p : p;
    endfunction

    function automatic bit allowed(int b);
        case (gate_code)
            2'b00:   return b == 0;
            2'b01:   return b == 2;
            2'b10:   return b != 1;
            default: return 1'b1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!mreset_n) begin
            for (int b = 0; b < 3; b++) begin
                running[b] = 0; pos[b] = 0; per[b] = 2;
            end
            refp = 0;
            oe_m = 0;
        end else begin
            bit ev;
            ev = mult_sel || (ref_lvl && !refp);
            refp = ref_lvl;
            oe_m = 1;
            for (int b = 0; b < 3; b++) begin
                if (ev) begin
                    if (running[b] != 0) begin
                        pos[b]++;
                        if (pos[b] == per[b]) begin
                            pos[b] = 0;
                            if (allowed(b)) per[b] = new_period(b);
                            else running[b] = 0;
                        end
                    end else if (allowed(b)) begin
                        running[b] = 1; pos[b] = 0; per[b] = new_period(b);
                    end
                end
            end
        end
    end

    task automatic check_bit(string req, string name, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) %s actual=%0b expected=%0b at %0t",
                     req, phase_tag, name, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic e [3];
        for (int b = 0; b < 3; b++)
            e[b] = mreset_n && (running[b] != 0) && (pos[b] < per[b] / 2);
        check_bit("R1", "qa0", qa[0], e[0]);
        check_bit("R2", "qb0", qb[0], e[1]);
        check_bit("R3", "qc0", qc[0], e[2]);
        check_bit("R8", "qa1", qa[1], qa[0]);
        check_bit("R8", "qb1", qb[1], qb[0]);
        check_bit("R8", "qc1", qc[1], qc[0]);
        check_bit("R11", "out_en", out_en, mreset_n && oe_m);
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            compare();
            if (ref_auto) begin
                ref_ph = (ref_ph + 1) % 5;
                ref_lvl = (ref_ph < 2);
            end
        end
    endtask

    initial begin
        // R7: reset state
        phase_tag = "R7";
        step(4);
        mreset_n = 1'b1;
        step(30);

        // R1 R2 R3 R4 R10: all select combinations under both halving settings
        for (int h = 0; h < 2; h++) begin
            for (int s = 0; s < 8; s++) begin
                phase_tag = (h == 1) ? "R4" : "R10";
                half_mode = h[0];
                {div_sel_a, div_sel_b, div_sel_c} = s[2:0];
                step(61);
            end
        end

        // R5 R9: every gate code, changed mid-phase
        half_mode = 1'b0;
        {div_sel_a, div_sel_b, div_sel_c} = 3'b101;
        for (int g = 0; g < 4; g++) begin
            phase_tag = (g[0]) ? "R9" : "R5";
            gate_code = g[1:0];
            step(47);
        end
        gate_code = 2'b01;
        step(13);
        gate_code = 2'b11;
        step(37);

        // R6: bypass with reference pattern
        phase_tag = "R6";
        mult_sel = 1'b0;
        ref_auto = 1'b1;
        half_mode = 1'b1;
        step(150);
        mult_sel = 1'b1;
        ref_auto = 1'b0;
        half_mode = 1'b0;

        // R7: reset mid-run and aligned restart
        phase_tag = "R7";
        step(7);
        mreset_n = 1'b0;
        step(3);
        mreset_n = 1'b1;
        step(40);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule